// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block sits on the host side of an 18-bit parallel RGB display link and runs on the dot clock. It produces an active-low line sync, an active-low frame sync, an active-high data enable and an 18-bit pixel bus (6 bits each of red, green and blue). Pixels come from an upstream source in raster order through a one-signal request: the block raises `pix_req` one dot clock before each visible pixel slot, and the source must present that pixel on `pix_data` at the next rising edge.

Each line is the sync pulse, then the back porch, then the visible pixels, then the front porch, all counted in dot clocks. Each frame follows the same pattern counted in lines. The visible area is set by parameters (240 x 320 by default). The six sync and porch widths are programmable. Writes land in a staging copy, and that copy is loaded into the working copy only at a frame boundary. A write outside the legal range of its field is dropped and sets a sticky error flag.

The `de_mode` input picks the framing. With it high, DE marks the pixel slots. With it low (sync-only framing), DE stays low and the panel finds the pixels by counting porches.

Top module: `rgb_panel_timing`

## Requirements
- R1: While reset is asserted, `lcd_hs_n` and `lcd_vs_n` are 1 and `lcd_de`, `lcd_rgb`, `pix_req` and `cfg_err` are 0.
- R2: After reset the working timing is line sync 10, line back porch 20, line front porch 10 (dot clocks), and frame sync 2, frame back porch 2, frame front porch 4 (lines). The line period is therefore 40 + H_ACT dot clocks.
- R3: With `de_mode`=1, `lcd_de` is high for exactly H_ACT consecutive dot clocks on each of V_ACT consecutive lines per frame. Those slots carry the requested pixels in the order they were requested.
- R4: In every cycle that is not a pixel slot, `lcd_rgb` is 0.
- R5: `pix_req` is high exactly one dot clock before each pixel slot, and `pix_data` is captured at the edge that ends the request cycle.
- R6: With `de_mode`=0, `lcd_de` stays 0, while the pixel slots and data on `lcd_rgb` stay in the same positions as in DE framing.
- R7: A timing write changes nothing in the frame in progress. It takes effect from the next frame start.
- R8: `cfg_sel` picks the field: 0 line sync (legal 2..16), 1 line back porch (2..24), 2 line front porch (2..16), 3 frame sync (1..4), 4 frame back porch (1..255), 5 frame front porch (3..255). A write with a value out of range, or with select 6 or 7, leaves all fields unchanged and sets `cfg_err`. Only reset clears `cfg_err`.
- R9: The smallest and largest legal values of each field produce exactly those widths on the outputs.
- R10: A frame starts in the cycle where `lcd_vs_n` falls, and `lcd_hs_n` falls in that same cycle. The frame sync lasts a whole number of lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de_mode | input | 1 | 1: DE framing, 0: sync-only framing |
| cfg_we | input | 1 | Timing field write strobe |
| cfg_sel | input | 3 | Timing field select |
| cfg_data | input | 8 | Timing field value |
| pix_req | output | 1 | Request for the next pixel |
| pix_data | input | 18 | Requested pixel, valid at the edge after `pix_req` |
| lcd_hs_n | output | 1 | Line sync, active low |
| lcd_vs_n | output | 1 | Frame sync, active low |
| lcd_de | output | 1 | Data enable, active high |
| lcd_rgb | output | 18 | Pixel bus |
| cfg_err | output | 1 | Sticky flag for a rejected write |

## Verification
The assertions assume that `de_mode` changes only during blanking, while no request is pending. They also assume that the source answers every request on the following edge. The bench changes the mode only at a frame start, which always falls inside frame sync. It updates `pix_data` on the falling edge after each request it observes. Timing writes are issued partway through a measured frame, so the deferred update can be seen by comparing that frame with the next one.

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing #(
  parameter int H_ACT = 240,
  parameter int V_ACT = 320,
  parameter int PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_mode,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  output logic             pix_req,
  input  logic [PIX_W-1:0] pix_data,
  output logic             lcd_hs_n,
  output logic             lcd_vs_n,
  output logic             lcd_de,
  output logic [PIX_W-1:0] lcd_rgb,
  output logic             cfg_err
);
  localparam int HW = $clog2(16 + 24 + H_ACT + 16 + 1);
  localparam int VW = $clog2(4 + 255 + V_ACT + 255 + 1);

  logic [4:0] st_hsw, st_hbp, st_hfp, hsw, hbp, hfp;
  logic [2:0] st_vsw, vsw;
  logic [7:0] st_vbp, st_vfp, vbp, vfp;
  logic [HW-1:0] hcnt, hstart, htot;
  logic [VW-1:0] vcnt, vstart, vtot;
  logic legal, h_last, v_last, h_act, v_act;

  always_comb begin
    case (cfg_sel)
      3'd0:    legal = cfg_data >= 8'd2 && cfg_data <= 8'd16;
      3'd1:    legal = cfg_data >= 8'd2 && cfg_data <= 8'd24;
      3'd2:    legal = cfg_data >= 8'd2 && cfg_data <= 8'd16;
      3'd3:    legal = cfg_data >= 8'd1 && cfg_data <= 8'd4;
      3'd4:    legal = cfg_data >= 8'd1;
      3'd5:    legal = cfg_data >= 8'd3;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_hsw <= 5'd10; st_hbp <= 5'd20; st_hfp <= 5'd10;
      st_vsw <= 3'd2;  st_vbp <= 8'd2;  st_vfp <= 8'd4;
      cfg_err <= 1'b0;
    end else if (cfg_we) begin
      if (!legal) cfg_err <= 1'b1;
      else begin
        case (cfg_sel)
          3'd0:    st_hsw <= cfg_data[4:0];
          3'd1:    st_hbp <= cfg_data[4:0];
          3'd2:    st_hfp <= cfg_data[4:0];
          3'd3:    st_vsw <= cfg_data[2:0];
          3'd4:    st_vbp <= cfg_data;
          default: st_vfp <= cfg_data;
        endcase
      end
    end
  end

  assign hstart = HW'(hsw) + HW'(hbp);
  assign htot   = hstart + HW'(H_ACT) + HW'(hfp);
  assign vstart = VW'(vsw) + VW'(vbp);
  assign vtot   = vstart + VW'(V_ACT) + VW'(vfp);
  assign h_last = hcnt == htot - HW'(1);
  assign v_last = vcnt == vtot - VW'(1);
  assign h_act  = hcnt >= hstart && hcnt < hstart + HW'(H_ACT);
  assign v_act  = vcnt >= vstart && vcnt < vstart + VW'(V_ACT);
  assign pix_req = h_act && v_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsw <= 5'd10; hbp <= 5'd20; hfp <= 5'd10;
      vsw <= 3'd2;  vbp <= 8'd2;  vfp <= 8'd4;
      hcnt <= '0; vcnt <= '0;
    end else begin
      hcnt <= h_last ? '0 : hcnt + HW'(1);
      if (h_last) vcnt <= v_last ? '0 : vcnt + VW'(1);
      if (h_last && v_last) begin
        hsw <= st_hsw; hbp <= st_hbp; hfp <= st_hfp;
        vsw <= st_vsw; vbp <= st_vbp; vfp <= st_vfp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_hs_n <= 1'b1;
      lcd_vs_n <= 1'b1;
      lcd_de   <= 1'b0;
      lcd_rgb  <= '0;
    end else begin
      lcd_hs_n <= !(hcnt < HW'(hsw));
      lcd_vs_n <= !(vcnt < VW'(vsw));
      lcd_de   <= pix_req && de_mode;
      lcd_rgb  <= pix_req ? pix_data : '0;
    end
  end
endmodule

// File: rtl/rgb_panel_timing_chk.sv
module rgb_panel_timing_chk #(
  parameter int PIX_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             de_mode,
  input logic             pix_req,
  input logic             lcd_hs_n,
  input logic             lcd_vs_n,
  input logic             lcd_de,
  input logic [PIX_W-1:0] lcd_rgb,
  input logic             cfg_err
);
  AST_REQ_THEN_DE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req && de_mode |=> lcd_de); // R5
  AST_NO_REQ_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> !lcd_de); // R5
  AST_SYNC_MODE_DE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !de_mode |=> !lcd_de); // R6
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> lcd_rgb == '0); // R4
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_vs_n) |-> !lcd_hs_n); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R8
  AST_HSYNC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_hs_n) |=> !lcd_hs_n); // R9
endmodule

bind rgb_panel_timing rgb_panel_timing_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .de_mode(de_mode), .pix_req(pix_req),
  .lcd_hs_n(lcd_hs_n), .lcd_vs_n(lcd_vs_n), .lcd_de(lcd_de),
  .lcd_rgb(lcd_rgb), .cfg_err(cfg_err)
);

// File: tb/test_rgb_panel_timing.sv
`timescale 1ns/1ps
module test_rgb_panel_timing;
  localparam int H = 8;
  localparam int V = 6;
  localparam int PW = 18;

  logic clk = 0, rst_n = 0, de_mode = 1, cfg_we = 0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [PW-1:0] pix_data = '0;
  logic pix_req, lcd_hs_n, lcd_vs_n, lcd_de, cfg_err;
  logic [PW-1:0] lcd_rgb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [PW-1:0] exp_q[$];
  logic [PW-1:0] pat = 18'h00101;
  bit prev_req = 0;
  int m_hsw, m_hbp, m_hfp, m_line, m_vsw, m_vbp, m_act, m_vfp, m_de, m_align;

  always #2 clk = ~clk;

  rgb_panel_timing #(.H_ACT(H), .V_ACT(V), .PIX_W(PW)) i_rgb_panel_timing (
    .clk(clk), .rst_n(rst_n), .de_mode(de_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pix_req(pix_req),
    .pix_data(pix_data), .lcd_hs_n(lcd_hs_n), .lcd_vs_n(lcd_vs_n),
    .lcd_de(lcd_de), .lcd_rgb(lcd_rgb), .cfg_err(cfg_err));

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // upstream source pushes expected pixels, monitor pops them from the slots
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req) begin
        if (exp_q.size() == 0) chk("R3 pixel with empty queue", 1, 0);
        else chk("R3 pixel order", int'(lcd_rgb), int'(exp_q.pop_front()));
      end else chk("R4 blank bus", int'(lcd_rgb), 0);
      chk("R5/R6 de vs request", int'(lcd_de), int'(prev_req && de_mode));
      prev_req = pix_req;
      if (pix_req) begin
        pix_data = pat;
        exp_q.push_back(pat);
        pat = pat * 18'd5 + 18'd7;
      end
    end
  end

  task automatic sync_frame();
    bit last = lcd_vs_n;
    forever begin
      @(negedge clk);
      if (!lcd_vs_n && last) break;
      last = lcd_vs_n;
    end
  endtask

  task automatic measure();
    bit hs[$], vs[$], de[$];
    bit last;
    int nl, fl, ll, f, l;
    hs.push_back(lcd_hs_n); vs.push_back(lcd_vs_n); de.push_back(lcd_de);
    last = lcd_vs_n;
    forever begin
      @(negedge clk);
      if (!lcd_vs_n && last) break;
      last = lcd_vs_n;
      hs.push_back(lcd_hs_n); vs.push_back(lcd_vs_n); de.push_back(lcd_de);
    end
    m_align = (hs[0] == 0 && vs[0] == 0) ? 1 : 0;
    m_hsw = 0; while (hs[m_hsw] == 0) m_hsw++;
    m_line = 0;
    for (int i = 1; i < hs.size(); i++)
      if (hs[i] == 0 && hs[i-1] == 1) begin m_line = i; break; end
    if (m_line == 0) m_line = hs.size();
    nl = hs.size() / m_line;
    m_vsw = 0; while (m_vsw < vs.size() && vs[m_vsw] == 0) m_vsw++;
    m_vsw = m_vsw / m_line;
    m_de = 0; fl = -1; ll = -1; f = -1; l = -1;
    for (int i = 0; i < de.size(); i++) if (de[i]) begin
      m_de++;
      if (fl < 0) fl = i / m_line;
      ll = i / m_line;
      if (i / m_line == fl) begin
        if (f < 0) f = i % m_line;
        l = i % m_line;
      end
    end
    m_hbp = f - m_hsw; m_hfp = m_line - 1 - l;
    m_vbp = fl - m_vsw; m_act = ll - fl + 1; m_vfp = nl - 1 - ll;
  endtask

  task automatic check_frame(string r, int hsw, int hbp, int hfp, int vsw, int vbp, int vfp);
    chk({r, " line sync"}, m_hsw, hsw);
    chk({r, " line period"}, m_line, hsw + hbp + H + hfp);
    chk({r, " line back porch"}, m_hbp, hbp);
    chk({r, " line front porch"}, m_hfp, hfp);
    chk({r, " frame sync lines"}, m_vsw, vsw);
    chk({r, " frame back porch"}, m_vbp, vbp);
    chk({r, " active lines"}, m_act, V);
    chk({r, " frame front porch"}, m_vfp, vfp);
    chk({r, " R3 de count"}, m_de, H * V);
    chk({r, " R10 sync alignment"}, m_align, 1);
  endtask

  task automatic wr(int sel, int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 hs_n in reset", int'(lcd_hs_n), 1);
    chk("R1 vs_n in reset", int'(lcd_vs_n), 1);
    chk("R1 de in reset", int'(lcd_de), 0);
    chk("R1 rgb in reset", int'(lcd_rgb), 0);
    chk("R1 req in reset", int'(pix_req), 0);
    chk("R1 err in reset", int'(cfg_err), 0);
    rst_n = 1;
    sync_frame();
    measure();
    check_frame("R2 defaults", 10, 20, 10, 2, 2, 4);
    fork
      measure();
      begin
        repeat (60) @(negedge clk);
        wr(0, 2); wr(1, 2); wr(2, 2); wr(3, 1); wr(4, 1); wr(5, 3);
      end
    join
    check_frame("R7 frame of the write", 10, 20, 10, 2, 2, 4);
    measure();
    check_frame("R9 minimum", 2, 2, 2, 1, 1, 3);
    chk("R8 err after legal writes", int'(cfg_err), 0);
    fork
      measure();
      begin
        repeat (10) @(negedge clk);
        wr(0, 1); wr(0, 17); wr(1, 25); wr(2, 1); wr(3, 0); wr(3, 5);
        wr(4, 0); wr(5, 2); wr(6, 9); wr(7, 9);
      end
    join
    chk("R8 err set", int'(cfg_err), 1);
    measure();
    check_frame("R8 illegal ignored", 2, 2, 2, 1, 1, 3);
    fork
      measure();
      begin
        repeat (10) @(negedge clk);
        wr(0, 16); wr(1, 24); wr(2, 16); wr(3, 4); wr(4, 5); wr(5, 7);
      end
    join
    measure();
    check_frame("R9 maximum", 16, 24, 16, 4, 5, 7);
    chk("R8 err still set", int'(cfg_err), 1);
    de_mode = 0;
    measure();
    chk("R6 no de in sync framing", m_de, 0);
    chk("R6 line period kept", m_line, 16 + 24 + H + 16);
    de_mode = 1;
    measure();
    check_frame("R3 back to de", 16, 24, 16, 4, 5, 7);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule